// File: doc/BRIEF.md
# Speculative Wakeup-Select Issue Queue with Load-Shadow Replay

This block is the issue stage of an out-of-order core. It holds up to `ENTRIES` renamed instructions. Each instruction has a left source tag, a right source tag, a destination tag, a load flag and an opaque micro-op payload. An entry may issue once both of its operands are ready. Every cycle, an oldest-first selector grants up to `ISSUE_W` ready entries. The destination tags of those grants are broadcast in the same cycle, so a consumer can issue in the cycle directly after its producer.

Every result is assumed to be available at issue time. A load is woken on the assumption that it hits in the data cache. The hit or miss outcome of a load arrives `SHADOW` cycles after the load issued. If the load missed, every instruction issued in those cycles goes back to waiting, whether or not it depends on the load. This is a non-selective replay. The missing load then parks until the fill port announces its tag. The fill port can also wake any other long-latency tag. An issued entry keeps its slot until its vulnerability window closes. Dispatch stalls while the queue is full.

Top module: `sched_iq`

## Requirements
- R1: After reset no issue slot is valid and `disp_ready` is high.
- R2: An entry requests issue only while both its operands are ready. An operand that was not ready becomes ready when its tag appears on an issue slot's destination broadcast or on the fill port.
- R3: The destination tag of a granted entry is broadcast in the cycle of the grant. A consumer of that tag that is already in the queue issues in the next cycle.
- R4: At most `ISSUE_W` entries are granted per cycle. Slot k drives `iss_dst[k*TAG_W +: TAG_W]`. Loads are granted only on slot 0. Slot 0 takes the oldest ready entry, and each higher slot takes the oldest remaining ready non-load.
- R5: Age is the order of dispatch. Among competing ready entries, the one dispatched first wins.
- R6: `lres_valid` is raised exactly `SHADOW` cycles after a load issues. When `lres_miss` is low (a hit), nothing is reissued.
- R7: In a cycle with `lres_valid` and `lres_miss` both high, no slot issues. Every entry issued in the previous `SHADOW` cycles, the missing load included, leaves the issued state. Replayed entries whose operands are still ready issue again in the following cycle.
- R8: The missing load is not reissued. Any operand that matches the destination tag of a replayed entry loses its ready flag. A fill carrying the load's tag frees the load and wakes its consumers, which issue in the next cycle.
- R9: An issued entry stays occupied for `SHADOW` cycles after its issue cycle and is freed only if no miss arrived in that time. `disp_ready` is low while every entry is occupied.
- R10: A dispatched operand also becomes ready from a broadcast in its own dispatch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free entry exists |
| disp_src_l | input | TAG_W | Left source tag |
| disp_rdy_l | input | 1 | Left source already available |
| disp_src_r | input | TAG_W | Right source tag |
| disp_rdy_r | input | 1 | Right source already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_load | input | 1 | Instruction is a load |
| disp_uop | input | UOP_W | Opaque payload |
| lres_valid | input | 1 | Load outcome for the load issued SHADOW cycles ago |
| lres_miss | input | 1 | That load missed |
| fill_valid | input | 1 | Completion broadcast |
| fill_tag | input | TAG_W | Tag being completed |
| iss_valid | output | ISSUE_W | Slot valid per issue slot |
| iss_dst | output | ISSUE_W*TAG_W | Destination tag per slot |
| iss_load | output | ISSUE_W | Slot carries a load |
| iss_uop | output | ISSUE_W*UOP_W | Payload per slot |

## Verification
The checks assume that the environment raises `lres_valid` only in the cycle when a load issued `SHADOW` cycles earlier reaches the end of its shadow. They also assume that destination tags in flight are unique and that no source is marked ready at dispatch unless its producer has already been broadcast. The stimulus is a fixed sequence of scenarios. It times every load outcome from the cycle in which that load is expected to issue, and it never reuses a tag while that tag is still live. Within these assumptions, every issue slot is compared against a scoreboard in every cycle, so any extra or missing issue is caught.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ISSUED = 2'd2,
    ST_FILL   = 2'd3
  } slot_state_e;

  // true when sequence number a was handed out before b (modulo 2**w)
  function automatic logic seq_before(input logic [15:0] a, input logic [15:0] b, input int w);
    logic [15:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  // lowest set bit as a one-hot vector
  function automatic logic [31:0] lowest_one(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int UOP_W  = 8,
  parameter int SEQ_W  = 4,
  parameter int NBC    = 3,
  parameter int NKILL  = 8,
  parameter int SHADOW = 3,
  localparam int CNT_W = $clog2(SHADOW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [TAG_W-1:0]       wr_src_l,
  input  logic                   wr_rdy_l,
  input  logic [TAG_W-1:0]       wr_src_r,
  input  logic                   wr_rdy_r,
  input  logic [TAG_W-1:0]       wr_dst,
  input  logic                   wr_load,
  input  logic [UOP_W-1:0]       wr_uop,
  input  logic [SEQ_W-1:0]       wr_seq,
  input  logic [NBC-1:0]         bc_vld,
  input  logic [NBC*TAG_W-1:0]   bc_tag,
  input  logic [NKILL-1:0]       kill_vld,
  input  logic [NKILL*TAG_W-1:0] kill_tag,
  input  logic                   grant,
  input  logic                   replay,
  input  logic                   fill_vld,
  input  logic [TAG_W-1:0]       fill_tag,
  output logic                   busy,
  output logic                   req,
  output logic                   issued,
  output logic                   load_due,
  output logic                   is_load,
  output logic [TAG_W-1:0]       dst,
  output logic [UOP_W-1:0]       uop,
  output logic [SEQ_W-1:0]       seq
);

  slot_state_e      st;
  logic [TAG_W-1:0] src_l, src_r;
  logic             rdy_l, rdy_r;
  logic [CNT_W-1:0] cnt;

  function automatic logic bc_seen(input logic [TAG_W-1:0] t,
                                   input logic [NBC-1:0] v,
                                   input logic [NBC*TAG_W-1:0] tags);
    logic h;
    h = 1'b0;
    for (int i = 0; i < NBC; i++)
      if (v[i] && tags[i*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  function automatic logic kill_seen(input logic [TAG_W-1:0] t,
                                     input logic [NKILL-1:0] v,
                                     input logic [NKILL*TAG_W-1:0] tags);
    logic h;
    h = 1'b0;
    for (int i = 0; i < NKILL; i++)
      if (v[i] && tags[i*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  // operand readiness for the next cycle, named for visibility
  logic new_rdy_l, new_rdy_r, upd_rdy_l, upd_rdy_r, shadow_closed;

  always_comb begin
    new_rdy_l = (wr_rdy_l | bc_seen(wr_src_l, bc_vld, bc_tag)) & ~kill_seen(wr_src_l, kill_vld, kill_tag);
    new_rdy_r = (wr_rdy_r | bc_seen(wr_src_r, bc_vld, bc_tag)) & ~kill_seen(wr_src_r, kill_vld, kill_tag);
    upd_rdy_l = (rdy_l | bc_seen(src_l, bc_vld, bc_tag)) & ~kill_seen(src_l, kill_vld, kill_tag);
    upd_rdy_r = (rdy_r | bc_seen(src_r, bc_vld, bc_tag)) & ~kill_seen(src_r, kill_vld, kill_tag);
    shadow_closed = (cnt == CNT_W'(SHADOW));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_FREE;
      src_l   <= '0;
      src_r   <= '0;
      rdy_l   <= 1'b0;
      rdy_r   <= 1'b0;
      dst     <= '0;
      is_load <= 1'b0;
      uop     <= '0;
      seq     <= '0;
      cnt     <= '0;
    end else begin
      unique case (st)
        ST_FREE: if (wr_en) begin
          st      <= ST_WAIT;
          src_l   <= wr_src_l;
          src_r   <= wr_src_r;
          rdy_l   <= new_rdy_l;
          rdy_r   <= new_rdy_r;
          dst     <= wr_dst;
          is_load <= wr_load;
          uop     <= wr_uop;
          seq     <= wr_seq;
          cnt     <= '0;
        end
        ST_WAIT: begin
          if (grant) begin
            st  <= ST_ISSUED;
            cnt <= CNT_W'(1);
          end else begin
            rdy_l <= upd_rdy_l;
            rdy_r <= upd_rdy_r;
          end
        end
        ST_ISSUED: begin
          if (replay) begin
            st    <= (is_load && shadow_closed) ? ST_FILL : ST_WAIT;
            rdy_l <= rdy_l & upd_rdy_l;
            rdy_r <= rdy_r & upd_rdy_r;
            cnt   <= '0;
          end else if (shadow_closed) begin
            st  <= ST_FREE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_FILL: if (fill_vld && fill_tag == dst) st <= ST_FREE;
        default: st <= ST_FREE;
      endcase
    end
  end

  assign busy     = (st != ST_FREE);
  assign req      = (st == ST_WAIT) && rdy_l && rdy_r;
  assign issued   = (st == ST_ISSUED);
  assign load_due = (st == ST_ISSUED) && is_load && shadow_closed;

endmodule

// File: rtl/sched_select.sv
module sched_select
  import sched_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 4
) (
  input  logic [ENTRIES-1:0]              req,
  input  logic [ENTRIES-1:0]              is_load,
  input  logic [ENTRIES*SEQ_W-1:0]        seq,
  input  logic                            block,
  output logic [ISSUE_W-1:0][ENTRIES-1:0] gnt
);

  always_comb begin
    logic [ENTRIES-1:0] taken;
    logic [ENTRIES-1:0] cand;
    logic               found;
    int                 best;
    taken = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      cand  = req & ~taken & {ENTRIES{~block}};
      if (k != 0) cand = cand & ~is_load;
      found = 1'b0;
      best  = 0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (cand[j] && (!found ||
            seq_before(16'(seq[j*SEQ_W +: SEQ_W]), 16'(seq[best*SEQ_W +: SEQ_W]), SEQ_W))) begin
          found = 1'b1;
          best  = j;
        end
      end
      gnt[k] = '0;
      if (found) gnt[k][best] = 1'b1;
      taken = taken | gnt[k];
    end
  end

endmodule

// File: rtl/sched_iq.sv
module sched_iq
  import sched_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int UOP_W   = 8,
  parameter int ISSUE_W = 2,
  parameter int SHADOW  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  output logic                     disp_ready,
  input  logic [TAG_W-1:0]         disp_src_l,
  input  logic                     disp_rdy_l,
  input  logic [TAG_W-1:0]         disp_src_r,
  input  logic                     disp_rdy_r,
  input  logic [TAG_W-1:0]         disp_dst,
  input  logic                     disp_load,
  input  logic [UOP_W-1:0]         disp_uop,
  input  logic                     lres_valid,
  input  logic                     lres_miss,
  input  logic                     fill_valid,
  input  logic [TAG_W-1:0]         fill_tag,
  output logic [ISSUE_W-1:0]       iss_valid,
  output logic [ISSUE_W*TAG_W-1:0] iss_dst,
  output logic [ISSUE_W-1:0]       iss_load,
  output logic [ISSUE_W*UOP_W-1:0] iss_uop
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SEQ_W = IDX_W + 1;
  localparam int NBC   = ISSUE_W + 1;

  // named internal events
  logic                              replay_now;
  logic                              disp_fire;
  logic                              load_due;
  logic [ENTRIES-1:0]                busy_vec, req_vec, issued_vec, due_vec, load_vec;
  logic [ENTRIES-1:0]                alloc_oh;
  logic [ENTRIES-1:0][TAG_W-1:0]     dst_arr;
  logic [ENTRIES-1:0][UOP_W-1:0]     uop_arr;
  logic [ENTRIES-1:0][SEQ_W-1:0]     seq_arr;
  logic [ISSUE_W-1:0][ENTRIES-1:0]   gnt;
  logic [ENTRIES-1:0]                gnt_any;
  logic [ENTRIES-1:0]                kill_vld;
  logic [NBC-1:0]                    bc_vld;
  logic [NBC*TAG_W-1:0]              bc_tag;
  logic [ISSUE_W-1:0][TAG_W-1:0]     iss_dst_arr;
  logic [ISSUE_W-1:0][UOP_W-1:0]     iss_uop_arr;
  logic [SEQ_W-1:0]                  seq_next;

  assign replay_now = lres_valid & lres_miss;
  assign disp_ready = ~&busy_vec;
  assign disp_fire  = disp_valid & disp_ready;
  assign alloc_oh   = ENTRIES'(lowest_one(32'(~busy_vec)));
  assign load_due   = |due_vec;
  assign kill_vld   = issued_vec & {ENTRIES{replay_now}};

  always_ff @(posedge clk) begin
    if (!rst_n)         seq_next <= '0;
    else if (disp_fire) seq_next <= seq_next + SEQ_W'(1);
  end

  sched_select #(
    .ENTRIES(ENTRIES), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W)
  ) u_select (
    .req(req_vec), .is_load(load_vec), .seq(seq_arr), .block(replay_now), .gnt(gnt)
  );

  always_comb begin
    gnt_any = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      gnt_any        = gnt_any | gnt[k];
      iss_valid[k]   = |gnt[k];
      iss_dst_arr[k] = '0;
      iss_uop_arr[k] = '0;
      iss_load[k]    = 1'b0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (gnt[k][j]) begin
          iss_dst_arr[k] = iss_dst_arr[k] | dst_arr[j];
          iss_uop_arr[k] = iss_uop_arr[k] | uop_arr[j];
          iss_load[k]    = iss_load[k] | load_vec[j];
        end
      end
    end
  end

  assign iss_dst = iss_dst_arr;
  assign iss_uop = iss_uop_arr;
  assign bc_vld  = {fill_valid, iss_valid};
  assign bc_tag  = {fill_tag, iss_dst};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    sched_slot #(
      .TAG_W(TAG_W), .UOP_W(UOP_W), .SEQ_W(SEQ_W),
      .NBC(NBC), .NKILL(ENTRIES), .SHADOW(SHADOW)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (disp_fire & alloc_oh[e]),
      .wr_src_l (disp_src_l),
      .wr_rdy_l (disp_rdy_l),
      .wr_src_r (disp_src_r),
      .wr_rdy_r (disp_rdy_r),
      .wr_dst   (disp_dst),
      .wr_load  (disp_load),
      .wr_uop   (disp_uop),
      .wr_seq   (seq_next),
      .bc_vld   (bc_vld),
      .bc_tag   (bc_tag),
      .kill_vld (kill_vld),
      .kill_tag (dst_arr),
      .grant    (gnt_any[e]),
      .replay   (replay_now),
      .fill_vld (fill_valid),
      .fill_tag (fill_tag),
      .busy     (busy_vec[e]),
      .req      (req_vec[e]),
      .issued   (issued_vec[e]),
      .load_due (due_vec[e]),
      .is_load  (load_vec[e]),
      .dst      (dst_arr[e]),
      .uop      (uop_arr[e]),
      .seq      (seq_arr[e])
    );
  end

endmodule

// File: rtl/sched_iq_chk.sv
module sched_iq_chk #(
  parameter int ENTRIES = 8,
  parameter int ISSUE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               replay_now,
  input logic               lres_valid,
  input logic               load_due,
  input logic               disp_fire,
  input logic [ISSUE_W-1:0] iss_valid,
  input logic [ISSUE_W-1:0] iss_load,
  input logic [ENTRIES-1:0] issued_vec,
  input logic [ENTRIES-1:0] busy_vec
);

  a_r7_quiet_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    replay_now |-> (iss_valid == '0));

  a_r7_shadow_drained: assert property (@(posedge clk) disable iff (!rst_n)
    replay_now |=> (issued_vec == '0));

  a_r6_outcome_timing: assert property (@(posedge clk) disable iff (!rst_n)
    lres_valid |-> load_due);

  a_r4_load_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_load >> 1) == '0);

  a_r9_no_phantom_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_fire |=> ($countones(busy_vec) <= $past($countones(busy_vec))));

endmodule

bind sched_iq sched_iq_chk #(.ENTRIES(ENTRIES), .ISSUE_W(ISSUE_W)) u_sched_iq_chk (
  .clk(clk), .rst_n(rst_n), .replay_now(replay_now), .lres_valid(lres_valid),
  .load_due(load_due), .disp_fire(disp_fire), .iss_valid(iss_valid),
  .iss_load(iss_load), .issued_vec(issued_vec), .busy_vec(busy_vec)
);

// File: tb/sched_iq_bench.sv
`timescale 1ns/1ps
module sched_iq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 0, disp_rdy_l = 0, disp_rdy_r = 0, disp_load = 0;
  logic [5:0] disp_src_l = 0, disp_src_r = 0, disp_dst = 0, fill_tag = 0;
  logic [7:0] disp_uop = 0;
  logic       lres_valid = 0, lres_miss = 0, fill_valid = 0;
  logic       disp_ready;
  logic [1:0] iss_valid, iss_load;
  logic [11:0] iss_dst;
  logic [15:0] iss_uop;

  int  cyc = 0, nchk = 0, nerr = 0;
  bit  mon_on = 0, done = 0;

  typedef struct { int cyc; logic [1:0] v; logic [5:0] d0; logic [5:0] d1; string req; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sched_iq u_sched_iq (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_src_l(disp_src_l), .disp_rdy_l(disp_rdy_l), .disp_src_r(disp_src_r),
    .disp_rdy_r(disp_rdy_r), .disp_dst(disp_dst), .disp_load(disp_load),
    .disp_uop(disp_uop), .lres_valid(lres_valid), .lres_miss(lres_miss),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .iss_valid(iss_valid),
    .iss_dst(iss_dst), .iss_load(iss_load), .iss_uop(iss_uop)
  );

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", r, what, cyc, act, expv);
    end
  endtask

  // driver helpers
  task automatic tick();
    @(posedge clk); #1;
    disp_valid = 0; lres_valid = 0; lres_miss = 0; fill_valid = 0;
  endtask

  task automatic dsp(input logic [5:0] sl, input logic rl, input logic [5:0] sr, input logic rr,
                     input logic [5:0] d, input logic ld);
    disp_valid = 1; disp_src_l = sl; disp_rdy_l = rl; disp_src_r = sr; disp_rdy_r = rr;
    disp_dst = d; disp_load = ld; disp_uop = {2'b0, d};
  endtask

  task automatic expect_iss(input int c, input logic [1:0] v, input logic [5:0] d0,
                            input logic [5:0] d1, input string r);
    exp_t e;
    e.cyc = c; e.v = v; e.d0 = d0; e.d1 = d1; e.req = r;
    exp_q.push_back(e);
  endtask

  // monitor: compares every cycle against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "iss_valid", 32'(iss_valid), 32'(e.v));
        if (e.v[0]) chk(e.req, "slot0 dst", 32'(iss_dst[5:0]), 32'(e.d0));
        if (e.v[1]) chk(e.req, "slot1 dst", 32'(iss_dst[11:6]), 32'(e.d1));
      end else begin
        chk("R2 idle", "iss_valid", 32'(iss_valid), 32'd0);
      end
    end
  end

  initial begin
    int c, d, f0, m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    chk("R1", "disp_ready", 32'(disp_ready), 32'd1);
    chk("R1", "iss_valid", 32'(iss_valid), 32'd0);
    mon_on = 1;

    // R3 and R10: back-to-back chain A -> B -> C
    tick(); c = cyc;
    dsp(6'd0, 1, 6'd0, 1, 6'd10, 0); expect_iss(c + 1, 2'b01, 6'd10, 6'd0, "R3");
    tick(); dsp(6'd10, 0, 6'd0, 1, 6'd11, 0); expect_iss(c + 2, 2'b01, 6'd11, 6'd0, "R10");
    tick(); dsp(6'd11, 0, 6'd0, 1, 6'd12, 0); expect_iss(c + 3, 2'b01, 6'd12, 6'd0, "R3");
    repeat (8) tick();

    // R4 and R5: four waiters on tag 20, one of them a load; slot1 refuses loads
    d = cyc;
    dsp(6'd20, 0, 6'd0, 1, 6'd21, 0); tick();
    dsp(6'd20, 0, 6'd0, 1, 6'd22, 1); tick();
    dsp(6'd20, 0, 6'd0, 1, 6'd23, 0); tick();
    dsp(6'd20, 0, 6'd0, 1, 6'd24, 0); tick();
    dsp(6'd0, 1, 6'd0, 1, 6'd20, 0);
    expect_iss(d + 5, 2'b01, 6'd20, 6'd0, "R2");
    expect_iss(d + 6, 2'b11, 6'd21, 6'd23, "R5");
    expect_iss(d + 7, 2'b11, 6'd22, 6'd24, "R4");
    while (cyc < d + 10) tick();
    lres_valid = 1; lres_miss = 0;   // R6: hit for the load issued at d+7
    repeat (8) tick();

    // R9: fill the queue, then release with the completion port (R2)
    f0 = cyc;
    for (int i = 0; i < 8; i++) begin
      dsp(6'd40, 0, 6'd0, 1, 6'(41 + i), 0);
      tick();
    end
    chk("R9", "disp_ready when full", 32'(disp_ready), 32'd0);
    fill_valid = 1; fill_tag = 6'd40;
    expect_iss(f0 + 9,  2'b11, 6'd41, 6'd42, "R2");
    expect_iss(f0 + 10, 2'b11, 6'd43, 6'd44, "R5");
    expect_iss(f0 + 11, 2'b11, 6'd45, 6'd46, "R5");
    expect_iss(f0 + 12, 2'b11, 6'd47, 6'd48, "R5");
    while (cyc < f0 + 12) tick();
    chk("R9", "disp_ready inside shadow", 32'(disp_ready), 32'd0);
    tick();
    chk("R9", "disp_ready after shadow", 32'(disp_ready), 32'd1);
    repeat (8) tick();

    // R7 and R8: load L misses; D depends on L, I independent, H depends on D
    m = cyc;
    dsp(6'd0, 1, 6'd0, 1, 6'd50, 1); expect_iss(m + 1, 2'b01, 6'd50, 6'd0, "R10");
    tick(); dsp(6'd50, 0, 6'd0, 1, 6'd51, 0); expect_iss(m + 2, 2'b01, 6'd51, 6'd0, "R10");
    tick(); dsp(6'd0, 1, 6'd0, 1, 6'd52, 0); expect_iss(m + 3, 2'b01, 6'd52, 6'd0, "R3");
    tick(); dsp(6'd51, 1, 6'd0, 1, 6'd53, 0);
    tick(); lres_valid = 1; lres_miss = 1;   // cycle m+4: R7 no issue here
    expect_iss(m + 5, 2'b01, 6'd52, 6'd0, "R7");
    while (cyc < m + 7) tick();
    fill_valid = 1; fill_tag = 6'd50;
    expect_iss(m + 8, 2'b01, 6'd51, 6'd0, "R8");
    expect_iss(m + 9, 2'b01, 6'd53, 6'd0, "R8");
    repeat (10) tick();

    mon_on = 0;
    chk("R2", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule